// File: doc/BRIEF.md
# Programmable Four-Input AND-OR-INVERT Function Unit

This unit evaluates a configurable Boolean function of four single-bit inputs, here called A, B, C and D, which arrive on `data_i` as bits 0, 1, 2 and 3. The function is a sum of four product terms. Inside each term, every input contributes one literal. A 2-bit code picks the literal's form: the input as is, the input inverted, a constant 0, or a don't-care. With these codes a term can be any AND of true and complemented inputs, or a fixed 0 or 1. The unit ORs the four terms and registers the result on the system clock. A typical use is to combine a PWM phase with a comparator result to gate a synchronous-rectifier drive.

Software writes each product term through a small register port. Every term register accepts exactly one write after reset and then locks. Later writes to a locked term are dropped until the next reset. The lock state of each term is visible on `lock_o`. Reset clears every code to the constant-0 form, so each term evaluates to 0 and the output stays low until a term is programmed.

All pins are plain level signals. No data stream passes through the unit, so there is no valid/ready handshake and no back-pressure.

Top module: `aoi_logic_unit`

## Requirements
- R1: While reset is held and after it is released, `y_o` is 0 and `lock_o` is all zeros. Until a term is written, `y_o` stays 0 for every input pattern.
- R2: Literal code 2'b00 forces that literal to 0, so its whole product term evaluates to 0 whatever the inputs are.
- R3: Literal code 2'b01 passes the selected input unchanged into the term.
- R4: Literal code 2'b10 passes the selected input inverted into the term.
- R5: Literal code 2'b11 makes the literal a constant 1 (don't-care). A term whose four codes are all 2'b11 is constant 1.
- R6: `y_o` is the OR of the four product terms. Each term is the AND of its four literals. In a term's 8-bit word, the code for input k sits at bits [2k+1:2k].
- R7: `y_o` reflects the inputs and configuration present at the previous rising clock edge, which is a latency of one cycle.
- R8: A write (`cfg_we_i` high, term number on `cfg_sel_i`) to an unlocked term stores `cfg_data_i` at the clock edge and sets bit `cfg_sel_i` of `lock_o` from the next cycle on.
- R9: A write to a term whose lock bit is set leaves that term's configuration and lock unchanged, so the output function is unchanged.
- R10: Each term locks independently. Writing one term neither locks nor alters any other term.
- R11: Reset clears all lock bits and all codes, and a term may then be written once again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| data_i | input | 4 | Function inputs; bit 0 = A, bit 1 = B, bit 2 = C, bit 3 = D |
| cfg_we_i | input | 1 | Configuration write strobe, one cycle per write |
| cfg_sel_i | input | 2 | Number of the product term being written |
| cfg_data_i | input | 8 | Literal codes for the term; input k at bits [2k+1:2k] |
| lock_o | output | 4 | Per-term lock status; bit t set once term t has been written |
| y_o | output | 1 | Registered sum-of-products result |

## Verification
The hardest state to reach from the ports is a term that is locked while other terms are still writable. Reaching it takes a write, then an attempted overwrite of the same term, then a write to a neighbouring term, all within one reset period. The stimulus builds each configuration in phases separated by resets. Inside a phase, it sends deliberate rewrites to locked terms with contrasting codes, so that a lost lock would show up as a change in `y_o`. A behavioural model tracks the codes and locks per term and computes the expected `y_o` each cycle. Input patterns are swept and pseudo-random, so every literal form is seen with both input polarities.

// File: rtl/aoi_pkg.sv
package aoi_pkg;
  typedef enum logic [1:0] {
    LIT_ZERO = 2'b00,
    LIT_TRUE = 2'b01,
    LIT_INV  = 2'b10,
    LIT_ANY  = 2'b11
  } lit_code_e;

  localparam int unsigned LIT_W = 2;

  function automatic logic lit_eval(input logic [LIT_W-1:0] code, input logic din);
    case (lit_code_e'(code))
      LIT_TRUE: lit_eval = din;
      LIT_INV:  lit_eval = ~din;
      LIT_ANY:  lit_eval = 1'b1;
      default:  lit_eval = 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/aoi_term_cfg.sv
module aoi_term_cfg #(
  parameter int unsigned CFG_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_i,
  input  logic [CFG_W-1:0] data_i,
  output logic [CFG_W-1:0] cfg_o,
  output logic             locked_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_o    <= '0;
      locked_o <= 1'b0;
    end else if (wr_i && !locked_o) begin
      cfg_o    <= data_i;
      locked_o <= 1'b1;
    end
  end

  // R8
  lock_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && !locked_o) |=> (locked_o && cfg_o == $past(data_i)));

  // R9
  locked_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    locked_o |=> (locked_o && $stable(cfg_o)));
endmodule

// File: rtl/aoi_product_term.sv
module aoi_product_term
  import aoi_pkg::*;
#(
  parameter int unsigned NUM_IN = 4
) (
  input  logic [NUM_IN-1:0]       data_i,
  input  logic [LIT_W*NUM_IN-1:0] code_i,
  output logic                    hit_o
);
  logic [NUM_IN-1:0] lit;

  for (genvar k = 0; k < NUM_IN; k++) begin : g_lit
    assign lit[k] = lit_eval(code_i[LIT_W*k +: LIT_W], data_i[k]);
  end

  assign hit_o = &lit;

  logic zero_seen;
  logic all_any;
  always_comb begin
    zero_seen = 1'b0;
    all_any   = 1'b1;
    for (int k = 0; k < NUM_IN; k++) begin
      if (code_i[LIT_W*k +: LIT_W] == LIT_ZERO) zero_seen = 1'b1;
      if (code_i[LIT_W*k +: LIT_W] != LIT_ANY)  all_any   = 1'b0;
    end
  end

  always_comb begin
    if (!$isunknown({code_i, data_i})) begin
      // R2
      zero_code_chk: assert (!(zero_seen && hit_o));
      // R5
      all_any_chk: assert (!all_any || hit_o);
    end
  end
endmodule

// File: rtl/aoi_logic_unit.sv
module aoi_logic_unit
  import aoi_pkg::*;
#(
  parameter int unsigned NUM_IN    = 4,
  parameter int unsigned NUM_TERMS = 4
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic [NUM_IN-1:0]                     data_i,
  input  logic                                  cfg_we_i,
  input  logic [$clog2(NUM_TERMS)-1:0]          cfg_sel_i,
  input  logic [LIT_W*NUM_IN-1:0]               cfg_data_i,
  output logic [NUM_TERMS-1:0]                  lock_o,
  output logic                                  y_o
);
  localparam int unsigned TERM_W = $clog2(NUM_TERMS);
  localparam int unsigned CFG_W  = LIT_W * NUM_IN;

  logic [NUM_TERMS-1:0] term_hit;
  logic [NUM_TERMS-1:0] term_wr;

  for (genvar t = 0; t < NUM_TERMS; t++) begin : g_term
    logic [CFG_W-1:0] cfg;

    assign term_wr[t] = cfg_we_i && (cfg_sel_i == TERM_W'(t));

    aoi_term_cfg #(.CFG_W(CFG_W)) i_cfg (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_i     (term_wr[t]),
      .data_i   (cfg_data_i),
      .cfg_o    (cfg),
      .locked_o (lock_o[t])
    );

    aoi_product_term #(.NUM_IN(NUM_IN)) i_term (
      .data_i (data_i),
      .code_i (cfg),
      .hit_o  (term_hit[t])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) y_o <= 1'b0;
    else        y_o <= |term_hit;
  end

  // R1
  unwritten_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_o == '0) |=> !y_o);

  // R10
  single_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(lock_o & ~$past(lock_o)) <= 1);

  // R10
  other_terms_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_we_i |=> (lock_o == $past(lock_o)));
endmodule

// File: tb/test_aoi_logic_unit.sv
module test_aoi_logic_unit;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] data_i = '0;
  logic       cfg_we_i = 1'b0;
  logic [1:0] cfg_sel_i = '0;
  logic [7:0] cfg_data_i = '0;
  logic [3:0] lock_o;
  logic       y_o;

  aoi_logic_unit i_aoi_logic_unit (
    .clk(clk), .rst_n(rst_n), .data_i(data_i), .cfg_we_i(cfg_we_i),
    .cfg_sel_i(cfg_sel_i), .cfg_data_i(cfg_data_i), .lock_o(lock_o), .y_o(y_o)
  );

  always #4 clk = ~clk;

  int n_checks = 0;
  int n_fail = 0;
  string cur_req = "R1";

  logic [7:0] m_cfg [4];
  bit   [3:0] m_lock;
  bit         exp_y;

  function automatic bit model_eval(input logic [3:0] din);
    bit any = 0;
    for (int t = 0; t < 4; t++) begin
      bit prod = 1;
      for (int k = 0; k < 4; k++) begin
        int code = m_cfg[t][2*k +: 2];
        bit lit;
        if (code == 0) lit = 0;
        else if (code == 1) lit = din[k];
        else if (code == 2) lit = !din[k];
        else lit = 1;
        prod = prod & lit;
      end
      any = any | prod;
    end
    return any;
  endfunction

  task automatic check(input string req, input int act, input int exp, input string what);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    if (!rst_n) begin
      exp_y = 0;
      m_lock = '0;
      for (int t = 0; t < 4; t++) m_cfg[t] = '0;
    end else begin
      exp_y = model_eval(data_i);
      if (cfg_we_i && !m_lock[cfg_sel_i]) begin
        m_cfg[cfg_sel_i] = cfg_data_i;
        m_lock[cfg_sel_i] = 1;
      end
    end
    #2;
    check(cur_req, y_o, exp_y, "y_o");
    check(cur_req, lock_o, m_lock, "lock_o");
  endtask

  task automatic do_reset();
    rst_n = 0;
    cfg_we_i = 0;
    tick();
    tick();
    rst_n = 1;
  endtask

  task automatic write_term(input int sel, input logic [7:0] d);
    cfg_we_i = 1;
    cfg_sel_i = 2'(sel);
    cfg_data_i = d;
    tick();
    cfg_we_i = 0;
  endtask

  task automatic sweep();
    for (int v = 0; v < 16; v++) begin
      data_i = 4'(v);
      tick();
    end
    tick();
  endtask

  initial begin
    #(8 * 100000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    #2;
    // R1: reset state and unwritten unit stays low
    cur_req = "R1";
    do_reset();
    check("R1", lock_o, 0, "lock after reset");
    sweep();

    // R5, R8: all don't-care term is constant 1, lock bit rises
    cur_req = "R5";
    write_term(0, 8'hFF);
    check("R8", lock_o, 4'b0001, "lock after first write");
    sweep();
    check("R5", y_o, 1, "constant-one term");

    // R9: rewrite of a locked term ignored
    cur_req = "R9";
    write_term(0, 8'h00);
    sweep();
    check("R9", y_o, 1, "after ignored rewrite");

    // R3, R7, R11: A true, others don't-care
    cur_req = "R3";
    do_reset();
    check("R11", lock_o, 0, "locks cleared by reset");
    write_term(0, 8'hFD);
    check("R11", lock_o, 4'b0001, "write accepted after reset");
    data_i = 4'b0001;
    tick();
    data_i = 4'b0000;
    #1 check("R7", y_o, 1, "one cycle after A high");
    tick();
    check("R7", y_o, 0, "one cycle after A low");
    cur_req = "R7";
    sweep();

    // R4: A inverted
    cur_req = "R4";
    do_reset();
    write_term(0, 8'hFE);
    sweep();

    // R2: B literal forced to zero
    cur_req = "R2";
    do_reset();
    write_term(2, 8'hF3);
    sweep();
    check("R2", y_o, 0, "term with forced-zero literal");

    // R6, R10: OR of A&B (term1) and C&~D (term2)
    cur_req = "R10";
    do_reset();
    write_term(1, 8'hF5);
    check("R10", lock_o, 4'b0010, "only term1 locked");
    write_term(2, 8'h9F);
    check("R10", lock_o, 4'b0110, "term1 and term2 locked");
    write_term(1, 8'hFF);
    cur_req = "R6";
    sweep();
    write_term(3, 8'h6F);
    check("R10", lock_o, 4'b1110, "term3 still writable");
    sweep();

    // R6: pseudo-random configuration and inputs
    for (int r = 0; r < 6; r++) begin
      do_reset();
      for (int t = 0; t < 4; t++) write_term(t, 8'($urandom));
      for (int i = 0; i < 60; i++) begin
        data_i = 4'($urandom);
        if (i % 7 == 3) begin
          cfg_we_i = 1;
          cfg_sel_i = 2'($urandom);
          cfg_data_i = 8'($urandom);
        end else begin
          cfg_we_i = 0;
        end
        tick();
      end
      cfg_we_i = 0;
    end

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule